// File: doc/BRIEF.md
# Variable-Length Instruction Field Framer

This block receives a stream of instruction bytes, one byte per valid/ready transfer, and cuts it into instructions, splitting each into its fields: up to four one-byte prefixes, an opcode of one to three bytes, an optional addressing byte (mode/register/rm), an optional scale-index-base byte, an optional displacement and an optional immediate. The lengths of the later fields are not known in advance. They follow from the opcode escape bytes, from the addressing byte and the scale-index-base byte under 32-bit addressing rules, and from a small per-opcode side input (addressing byte present, immediate size) that the byte source supplies.

Each finished instruction yields one record. The record holds the prefix group flags and bytes, the packed opcode, the split addressing fields, the displacement and immediate values, the byte count and an error flag. The record stays on the output until the consumer takes it. A repeated prefix group is flagged. An instruction that has too many prefixes, or that grows past the length limit, is closed at once with the error flag set, and parsing restarts on the following byte.

Top module: `insn_framer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Prefix bytes are sorted by value into groups, in any arrival order. Group 1 holds F0h, F2h and F3h: it sets out_pfx_mask bit 0 and the byte is given on out_g1_byte. Group 2 holds 26h, 2Eh, 36h, 3Eh, 64h and 65h: it sets bit 1 and the byte is given on out_g2_byte. 66h sets bit 2 and 67h sets bit 3. out_pfx_count gives the number of prefix bytes, and an absent group leaves its byte output at 00h.
- R3: A second prefix from a group that is already set raises out_err. The first byte of that group is the one kept, and parsing goes on to the end of the instruction.
- R4: A prefix byte that arrives after MAX_PFX (default 4) prefixes closes the record at once with out_err=1, out_len=MAX_PFX+1 and out_opc_len=0. The next byte starts a new instruction.
- R5: A first opcode byte of 0Fh extends the opcode to two bytes. A second byte of 38h or 3Ah extends it to three. out_opcode holds the first byte in bits 7:0, the second in bits 15:8 and the third in bits 23:16, and out_opc_len gives the byte count.
- R6: hint_modrm and hint_imm_code are used only in the cycle in which the last opcode byte is accepted. The imm code maps 0→0, 1→1, 2→2 and 3→4 bytes.
- R7: The addressing byte gives out_mod from bits 7:6, out_reg from bits 5:3 and out_rm from bits 2:0. A scale-index-base byte follows it when mod≠3 and rm=4, and gives out_scale from bits 7:6, out_index from bits 5:3 and out_base from bits 2:0.
- R8: The displacement is 1 byte when mod=1 and 4 bytes when mod=2. It is also 4 bytes when mod=0 and rm=5, or when mod=0 and the base is 5. In every other case it is absent.
- R9: Displacement and immediate bytes are assembled least significant byte first into out_disp and out_imm, and the bits above the field size are zero.
- R10: For a legal instruction, out_len equals the number of bytes consumed and out_err is 0.
- R11: When the byte that makes the count MAX_LEN (default 15) does not finish the instruction, the record closes with out_err=1 and out_len=MAX_LEN. The next byte starts a new instruction.
- R12: While out_valid=1 and out_ready=0, the record stays stable and in_ready is 0. With out_ready=1, the old record can be taken and a new one loaded on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted on this edge when valid |
| hint_modrm | input | 1 | Opcode takes an addressing byte |
| hint_imm_code | input | 2 | Immediate size code for the opcode |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_len | output | 4 | Instruction length in bytes |
| out_err | output | 1 | Malformed instruction |
| out_pfx_count | output | 3 | Number of prefix bytes |
| out_pfx_mask | output | 4 | Group-present flags, bit n = group n+1 |
| out_g1_byte | output | 8 | Group 1 prefix byte |
| out_g2_byte | output | 8 | Group 2 prefix byte |
| out_opc_len | output | 2 | Opcode byte count |
| out_opcode | output | 24 | Opcode bytes, first byte lowest |
| out_has_modrm | output | 1 | Addressing byte present |
| out_mod | output | 2 | Addressing mode |
| out_reg | output | 3 | Register / opcode extension |
| out_rm | output | 3 | Register / memory operand |
| out_has_sib | output | 1 | Scale-index-base byte present |
| out_scale | output | 2 | Scale |
| out_index | output | 3 | Index |
| out_base | output | 3 | Base |
| out_disp_len | output | 3 | Displacement bytes |
| out_disp | output | 32 | Displacement value |
| out_imm_len | output | 3 | Immediate bytes |
| out_imm | output | 32 | Immediate value |

## Verification
Taking a record and completing the next instruction can happen in the same cycle. Retirement and completion then meet at the output register. The bench brings this about by stalling a finished record with out_ready low while the next single-byte instruction waits, and then raising out_ready. At the next sample the bench expects the newer opcode, with no lost or repeated record. A back-to-back stream of single-byte instructions with out_ready held high covers the same overlap on every edge.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
   localparam int BYTE_W  = 8;
   localparam int FIELD_W = 32;
   localparam int OPC_W   = 3 * BYTE_W;
   localparam int LEN_W   = 4;
   localparam int PCNT_W  = 3;
   localparam int NGRP    = 4;

   typedef enum logic [2:0] {
      PH_PFX, PH_OP2, PH_OP3, PH_MODRM, PH_SIB, PH_DISP, PH_IMM
   } phase_e;

   typedef struct packed {
      logic [LEN_W-1:0]   len;
      logic [PCNT_W-1:0]  pfx_cnt;
      logic [NGRP-1:0]    grp_mask;
      logic [BYTE_W-1:0]  g1_byte;
      logic [BYTE_W-1:0]  g2_byte;
      logic               err;
      logic [1:0]         opc_len;
      logic [OPC_W-1:0]   opcode;
      logic               has_modrm;
      logic [BYTE_W-1:0]  modrm;
      logic               has_sib;
      logic [BYTE_W-1:0]  sib;
      logic [2:0]         disp_len;
      logic [FIELD_W-1:0] disp;
      logic [2:0]         imm_len;
      logic [FIELD_W-1:0] imm;
   } frame_t;

   function automatic logic [2:0] code_to_bytes(input logic [1:0] code);
      return (code == 2'd3) ? 3'd4 : {1'b0, code};
   endfunction
endpackage

// File: rtl/ifr_prefix_class.sv
module ifr_prefix_class
   import ifr_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_in,
   output logic              is_pfx,
   output logic [1:0]        grp
);
   localparam int NCODE = 11;
   localparam logic [BYTE_W-1:0] CODE [NCODE] = '{
      8'hF0, 8'hF2, 8'hF3,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67
   };
   localparam logic [1:0] GRP [NCODE] = '{
      2'd0, 2'd0, 2'd0,
      2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1,
      2'd2, 2'd3
   };

   logic [NCODE-1:0] hit;

   for (genvar i = 0; i < NCODE; i++) begin : g_cmp
      assign hit[i] = (byte_in == CODE[i]);
   end

   assign is_pfx = |hit;

   always_comb begin
      grp = 2'd0;
      for (int i = 0; i < NCODE; i++) begin
         if (hit[i]) grp = GRP[i];
      end
   end
endmodule

// File: rtl/ifr_addr_decode.sv
module ifr_addr_decode (
   input  logic [1:0] mode,
   input  logic [2:0] rm,
   input  logic [2:0] base,
   output logic       need_sib,
   output logic [2:0] disp_len
);
   assign need_sib = (mode != 2'd3) && (rm == 3'd4);

   always_comb begin
      unique case (mode)
         2'd1:    disp_len = 3'd1;
         2'd2:    disp_len = 3'd4;
         2'd0: begin
            if (rm == 3'd5)                       disp_len = 3'd4;
            else if (rm == 3'd4 && base == 3'd5)  disp_len = 3'd4;
            else                                  disp_len = 3'd0;
         end
         default: disp_len = 3'd0;
      endcase
   end
endmodule

// File: rtl/ifr_sequencer.sv
module ifr_sequencer
   import ifr_pkg::*;
#(
   parameter int MAX_LEN = 15,
   parameter int MAX_PFX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [BYTE_W-1:0] din,
   input  logic              hint_modrm,
   input  logic [1:0]        hint_imm_code,
   input  logic              is_pfx,
   input  logic [1:0]        grp,
   input  logic              need_sib,
   input  logic [2:0]        dec_len,
   output logic [1:0]        dec_mod,
   output logic [2:0]        dec_rm,
   output logic [2:0]        dec_base,
   output frame_t            rec,
   output logic              rec_load
);
   phase_e     ph_q, ph_n;
   frame_t     w_q, w_n;
   logic [1:0] idx_q, idx_n;
   logic       done, abort;
   logic       take_final, after_addr, after_disp, go_imm;
   logic [BYTE_W-1:0] dec_modrm;

   assign dec_modrm = (ph_q == PH_MODRM) ? din : w_q.modrm;
   assign dec_mod   = dec_modrm[7:6];
   assign dec_rm    = dec_modrm[2:0];
   assign dec_base  = din[2:0];

   always_comb begin
      w_n        = w_q;
      ph_n       = ph_q;
      idx_n      = idx_q;
      done       = 1'b0;
      abort      = 1'b0;
      take_final = 1'b0;
      after_addr = 1'b0;
      after_disp = 1'b0;
      go_imm     = 1'b0;
      w_n.len    = w_q.len + 1'b1;

      unique case (ph_q)
         PH_PFX: begin
            if (is_pfx) begin
               if (w_q.pfx_cnt == PCNT_W'(MAX_PFX)) begin
                  w_n.err = 1'b1;
                  abort   = 1'b1;
               end else begin
                  w_n.pfx_cnt = w_q.pfx_cnt + 1'b1;
                  if (w_q.grp_mask[grp]) begin
                     w_n.err = 1'b1;
                  end else begin
                     w_n.grp_mask[grp] = 1'b1;
                     if (grp == 2'd0) w_n.g1_byte = din;
                     if (grp == 2'd1) w_n.g2_byte = din;
                  end
               end
            end else begin
               w_n.opcode[7:0] = din;
               w_n.opc_len     = 2'd1;
               if (din == 8'h0F) ph_n = PH_OP2;
               else              take_final = 1'b1;
            end
         end
         PH_OP2: begin
            w_n.opcode[15:8] = din;
            w_n.opc_len      = 2'd2;
            if (din == 8'h38 || din == 8'h3A) ph_n = PH_OP3;
            else                              take_final = 1'b1;
         end
         PH_OP3: begin
            w_n.opcode[23:16] = din;
            w_n.opc_len       = 2'd3;
            take_final        = 1'b1;
         end
         PH_MODRM: begin
            w_n.modrm = din;
            if (need_sib) begin
               w_n.has_sib = 1'b1;
               ph_n        = PH_SIB;
            end else begin
               w_n.disp_len = dec_len;
               after_addr   = 1'b1;
            end
         end
         PH_SIB: begin
            w_n.sib      = din;
            w_n.disp_len = dec_len;
            after_addr   = 1'b1;
         end
         PH_DISP: begin
            w_n.disp[{idx_q, 3'b000} +: BYTE_W] = din;
            idx_n = idx_q + 1'b1;
            if ({1'b0, idx_q} + 3'd1 == w_q.disp_len) after_disp = 1'b1;
         end
         PH_IMM: begin
            w_n.imm[{idx_q, 3'b000} +: BYTE_W] = din;
            idx_n = idx_q + 1'b1;
            if ({1'b0, idx_q} + 3'd1 == w_q.imm_len) done = 1'b1;
         end
         default: ph_n = PH_PFX;
      endcase

      if (take_final) begin
         w_n.has_modrm = hint_modrm;
         w_n.imm_len   = code_to_bytes(hint_imm_code);
         if (hint_modrm) ph_n = PH_MODRM;
         else            go_imm = 1'b1;
      end
      if (after_addr) begin
         if (w_n.disp_len != 3'd0) begin
            ph_n  = PH_DISP;
            idx_n = 2'd0;
         end else begin
            go_imm = 1'b1;
         end
      end
      if (after_disp) go_imm = 1'b1;
      if (go_imm) begin
         if (w_n.imm_len != 3'd0) begin
            ph_n  = PH_IMM;
            idx_n = 2'd0;
         end else begin
            done = 1'b1;
         end
      end

      if (!done && !abort && w_n.len == LEN_W'(MAX_LEN)) begin
         w_n.err = 1'b1;
         abort   = 1'b1;
      end
   end

   assign rec      = w_n;
   assign rec_load = accept && (done || abort);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q   <= '0;
         ph_q  <= PH_PFX;
         idx_q <= 2'd0;
      end else if (accept) begin
         if (done || abort) begin
            w_q   <= '0;
            ph_q  <= PH_PFX;
            idx_q <= 2'd0;
         end else begin
            w_q   <= w_n;
            ph_q  <= ph_n;
            idx_q <= idx_n;
         end
      end
   end
endmodule

// File: rtl/ifr_record_reg.sv
module ifr_record_reg
   import ifr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  frame_t rec_in,
   input  logic   take,
   output logic   valid,
   output logic   space,
   output frame_t rec_out
);
   assign space = !valid || take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         rec_out <= '0;
      end else if (load) begin
         valid   <= 1'b1;
         rec_out <= rec_in;
      end else if (take) begin
         valid   <= 1'b0;
      end
   end
endmodule

// File: rtl/insn_framer.sv
module insn_framer
   import ifr_pkg::*;
#(
   parameter int MAX_LEN = 15,
   parameter int MAX_PFX = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   input  logic        hint_modrm,
   input  logic [1:0]  hint_imm_code,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [3:0]  out_len,
   output logic        out_err,
   output logic [2:0]  out_pfx_count,
   output logic [3:0]  out_pfx_mask,
   output logic [7:0]  out_g1_byte,
   output logic [7:0]  out_g2_byte,
   output logic [1:0]  out_opc_len,
   output logic [23:0] out_opcode,
   output logic        out_has_modrm,
   output logic [1:0]  out_mod,
   output logic [2:0]  out_reg,
   output logic [2:0]  out_rm,
   output logic        out_has_sib,
   output logic [1:0]  out_scale,
   output logic [2:0]  out_index,
   output logic [2:0]  out_base,
   output logic [2:0]  out_disp_len,
   output logic [31:0] out_disp,
   output logic [2:0]  out_imm_len,
   output logic [31:0] out_imm
);
   if (MAX_LEN < 2 || MAX_LEN > (1 << LEN_W) - 1) begin : g_bad_len
      $error("insn_framer: MAX_LEN out of range");
   end
   if (MAX_PFX < 1 || MAX_PFX >= (1 << PCNT_W) || MAX_PFX >= MAX_LEN) begin : g_bad_pfx
      $error("insn_framer: MAX_PFX out of range");
   end

   logic       accept, is_pfx, need_sib, rec_load;
   logic [1:0] grp, dec_mod;
   logic [2:0] dec_rm, dec_base, dec_len;
   frame_t     rec_n, rec_q;

   assign accept = in_valid && in_ready;

   ifr_prefix_class i_class (
      .byte_in (in_data),
      .is_pfx  (is_pfx),
      .grp     (grp)
   );

   ifr_addr_decode i_addr (
      .mode     (dec_mod),
      .rm       (dec_rm),
      .base     (dec_base),
      .need_sib (need_sib),
      .disp_len (dec_len)
   );

   ifr_sequencer #(.MAX_LEN(MAX_LEN), .MAX_PFX(MAX_PFX)) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept        (accept),
      .din           (in_data),
      .hint_modrm    (hint_modrm),
      .hint_imm_code (hint_imm_code),
      .is_pfx        (is_pfx),
      .grp           (grp),
      .need_sib      (need_sib),
      .dec_len       (dec_len),
      .dec_mod       (dec_mod),
      .dec_rm        (dec_rm),
      .dec_base      (dec_base),
      .rec           (rec_n),
      .rec_load      (rec_load)
   );

   ifr_record_reg i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rec_load),
      .rec_in  (rec_n),
      .take    (out_ready),
      .valid   (out_valid),
      .space   (in_ready),
      .rec_out (rec_q)
   );

   assign out_len       = rec_q.len;
   assign out_err       = rec_q.err;
   assign out_pfx_count = rec_q.pfx_cnt;
   assign out_pfx_mask  = rec_q.grp_mask;
   assign out_g1_byte   = rec_q.g1_byte;
   assign out_g2_byte   = rec_q.g2_byte;
   assign out_opc_len   = rec_q.opc_len;
   assign out_opcode    = rec_q.opcode;
   assign out_has_modrm = rec_q.has_modrm;
   assign out_mod       = rec_q.modrm[7:6];
   assign out_reg       = rec_q.modrm[5:3];
   assign out_rm        = rec_q.modrm[2:0];
   assign out_has_sib   = rec_q.has_sib;
   assign out_scale     = rec_q.sib[7:6];
   assign out_index     = rec_q.sib[5:3];
   assign out_base      = rec_q.sib[2:0];
   assign out_disp_len  = rec_q.disp_len;
   assign out_disp      = rec_q.disp;
   assign out_imm_len   = rec_q.imm_len;
   assign out_imm       = rec_q.imm;
endmodule

// File: rtl/insn_framer_chk.sv
module insn_framer_chk #(
   parameter int MAX_LEN = 15,
   parameter int MAX_PFX = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [3:0]  out_len,
   input logic        out_err,
   input logic [3:0]  out_pfx_mask,
   input logic [1:0]  out_opc_len,
   input logic [23:0] out_opcode,
   input logic        out_has_modrm,
   input logic [1:0]  out_mod,
   input logic [2:0]  out_rm,
   input logic        out_has_sib,
   input logic [2:0]  out_disp_len,
   input logic [31:0] out_disp,
   input logic [2:0]  out_imm_len
);
   a_r12_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   a_r12_record_held: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_len)
                                  && $stable(out_disp));

   a_r11_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_len != 4'd0 && 32'(out_len) <= MAX_LEN);

   a_r7_sib_only_for_memory: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_has_sib |-> out_has_modrm && out_mod != 2'd3 && out_rm == 3'd4);

   a_r8_short_disp: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && out_has_modrm && out_mod == 2'd1 |-> out_disp_len == 3'd1);

   a_r8_register_form: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && out_has_modrm && out_mod == 2'd3 |-> out_disp_len == 3'd0 && !out_has_sib);

   a_r5_opcode_present: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |-> out_opc_len != 2'd0);

   a_r4_prefix_overflow_len: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err && out_opc_len == 2'd0 |-> 32'(out_len) == MAX_PFX + 1);

   a_r10_len_sums_fields: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |-> 6'(out_len) == 6'($countones(out_pfx_mask)) + 6'(out_opc_len)
         + 6'(out_has_modrm) + 6'(out_has_sib) + 6'(out_disp_len) + 6'(out_imm_len));
endmodule

bind insn_framer insn_framer_chk #(.MAX_LEN(MAX_LEN), .MAX_PFX(MAX_PFX)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_ready      (in_ready),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_len       (out_len),
   .out_err       (out_err),
   .out_pfx_mask  (out_pfx_mask),
   .out_opc_len   (out_opc_len),
   .out_opcode    (out_opcode),
   .out_has_modrm (out_has_modrm),
   .out_mod       (out_mod),
   .out_rm        (out_rm),
   .out_has_sib   (out_has_sib),
   .out_disp_len  (out_disp_len),
   .out_disp      (out_disp),
   .out_imm_len   (out_imm_len)
);

// File: tb/test_insn_framer.sv
`timescale 1ns/100ps
module test_insn_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic        hint_modrm = 1'b0;
   logic [1:0]  hint_imm_code = 2'd0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [3:0]  out_len;
   logic        out_err;
   logic [2:0]  out_pfx_count;
   logic [3:0]  out_pfx_mask;
   logic [7:0]  out_g1_byte, out_g2_byte;
   logic [1:0]  out_opc_len;
   logic [23:0] out_opcode;
   logic        out_has_modrm, out_has_sib;
   logic [1:0]  out_mod, out_scale;
   logic [2:0]  out_reg, out_rm, out_index, out_base;
   logic [2:0]  out_disp_len, out_imm_len;
   logic [31:0] out_disp, out_imm;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   insn_framer i_insn_framer (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input logic m = 1'b0, input logic [1:0] ic = 2'd0);
      in_valid      = 1'b1;
      in_data       = b;
      hint_modrm    = m;
      hint_imm_code = ic;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid      = 1'b0;
   endtask

   task automatic pop();
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 out_valid", 32'(out_valid), 32'd0);
      chk("R1 in_ready", 32'(in_ready), 32'd1);
   endtask

   task automatic t_prefixes();
      send(8'h65); send(8'hF3); send(8'h66); send(8'h67); send(8'h90);
      chk("R2 valid", 32'(out_valid), 32'd1);
      chk("R2 mask", 32'(out_pfx_mask), 32'hF);
      chk("R2 g1", 32'(out_g1_byte), 32'hF3);
      chk("R2 g2", 32'(out_g2_byte), 32'h65);
      chk("R2 count", 32'(out_pfx_count), 32'd4);
      chk("R10 len", 32'(out_len), 32'd5);
      chk("R10 err", 32'(out_err), 32'd0);
      pop();
      send(8'h2E); send(8'hC3);
      chk("R2 mask single", 32'(out_pfx_mask), 32'h2);
      chk("R2 g1 absent", 32'(out_g1_byte), 32'h00);
      chk("R2 g2 seg", 32'(out_g2_byte), 32'h2E);
      pop();
   endtask

   task automatic t_dup();
      send(8'hF2); send(8'hF0); send(8'h90);
      chk("R3 err", 32'(out_err), 32'd1);
      chk("R3 first kept", 32'(out_g1_byte), 32'hF2);
      chk("R3 len", 32'(out_len), 32'd3);
      chk("R3 opcode", 32'(out_opcode), 32'h90);
      pop();
   endtask

   task automatic t_fifth();
      send(8'h66); send(8'h67); send(8'hF0); send(8'h2E); send(8'h26);
      chk("R4 valid", 32'(out_valid), 32'd1);
      chk("R4 err", 32'(out_err), 32'd1);
      chk("R4 len", 32'(out_len), 32'd5);
      chk("R4 opc_len", 32'(out_opc_len), 32'd0);
      pop();
      send(8'h90);
      chk("R4 resync len", 32'(out_len), 32'd1);
      chk("R4 resync err", 32'(out_err), 32'd0);
      chk("R4 resync mask", 32'(out_pfx_mask), 32'd0);
      pop();
   endtask

   task automatic t_escape();
      send(8'h0F); send(8'h05);
      chk("R5 two-byte len", 32'(out_opc_len), 32'd2);
      chk("R5 two-byte opcode", 32'(out_opcode), 32'h00050F);
      pop();
      send(8'h0F); send(8'h38); send(8'h00, 1'b1); send(8'hC1);
      chk("R5 three-byte len", 32'(out_opc_len), 32'd3);
      chk("R5 three-byte opcode", 32'(out_opcode), 32'h00380F);
      chk("R7 mod", 32'(out_mod), 32'd3);
      chk("R7 rm", 32'(out_rm), 32'd1);
      chk("R8 no disp reg form", 32'(out_disp_len), 32'd0);
      chk("R10 len", 32'(out_len), 32'd4);
      pop();
   endtask

   task automatic t_hint();
      send(8'h66, 1'b1, 2'd3);
      send(8'hB8, 1'b0, 2'd3);
      send(8'h78); send(8'h56); send(8'h34); send(8'h12);
      chk("R6 hint only on last opcode", 32'(out_has_modrm), 32'd0);
      chk("R6 imm len", 32'(out_imm_len), 32'd4);
      chk("R9 imm value", out_imm, 32'h12345678);
      chk("R10 len", 32'(out_len), 32'd6);
      pop();
   endtask

   task automatic t_addr();
      send(8'h8B, 1'b1); send(8'h44); send(8'h24); send(8'h08);
      chk("R7 sib present", 32'(out_has_sib), 32'd1);
      chk("R7 reg", 32'(out_reg), 32'd0);
      chk("R7 index", 32'(out_index), 32'd4);
      chk("R8 mod1 disp len", 32'(out_disp_len), 32'd1);
      chk("R9 disp8", out_disp, 32'h08);
      pop();
      send(8'h8B, 1'b1); send(8'h05);
      send(8'hEF); send(8'hBE); send(8'hAD); send(8'hDE);
      chk("R8 rm5 no sib", 32'(out_has_sib), 32'd0);
      chk("R8 rm5 disp len", 32'(out_disp_len), 32'd4);
      chk("R9 disp32", out_disp, 32'hDEADBEEF);
      pop();
      send(8'h8B, 1'b1); send(8'h04); send(8'h25);
      send(8'h01); send(8'h02); send(8'h03); send(8'h04);
      chk("R8 base5 disp len", 32'(out_disp_len), 32'd4);
      chk("R7 base", 32'(out_base), 32'd5);
      chk("R9 disp order", out_disp, 32'h04030201);
      chk("R10 len", 32'(out_len), 32'd7);
      pop();
      send(8'h8B, 1'b1); send(8'h04); send(8'h24);
      chk("R8 base4 no disp", 32'(out_disp_len), 32'd0);
      chk("R10 len", 32'(out_len), 32'd3);
      pop();
      send(8'hC7, 1'b1, 2'd2); send(8'h84); send(8'h88);
      send(8'h10); send(8'h20); send(8'h30); send(8'h40);
      send(8'h34); send(8'h12);
      chk("R7 scale", 32'(out_scale), 32'd2);
      chk("R7 index", 32'(out_index), 32'd1);
      chk("R8 mod2 disp len", 32'(out_disp_len), 32'd4);
      chk("R9 imm16", out_imm, 32'h1234);
      chk("R10 len", 32'(out_len), 32'd9);
      pop();
   endtask

   task automatic t_limit();
      send(8'h66); send(8'h67); send(8'hF0); send(8'h2E);
      send(8'h0F); send(8'h38); send(8'h00, 1'b1, 2'd3);
      send(8'h84); send(8'h00);
      send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      send(8'hAA);
      chk("R11 not early", 32'(out_valid), 32'd0);
      send(8'hBB);
      chk("R11 closed", 32'(out_valid), 32'd1);
      chk("R11 err", 32'(out_err), 32'd1);
      chk("R11 len", 32'(out_len), 32'd15);
      pop();
      send(8'h90);
      chk("R11 resync len", 32'(out_len), 32'd1);
      chk("R11 resync err", 32'(out_err), 32'd0);
      pop();
   endtask

   task automatic t_handshake();
      send(8'h90);
      in_valid = 1'b1; in_data = 8'hC3; hint_modrm = 1'b0; hint_imm_code = 2'd0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R12 stall in_ready", 32'(in_ready), 32'd0);
         chk("R12 held opcode", 32'(out_opcode), 32'h90);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      chk("R12 overlap valid", 32'(out_valid), 32'd1);
      chk("R12 overlap opcode", 32'(out_opcode), 32'hC3);
      pop();
      chk("R12 drained", 32'(out_valid), 32'd0);
      out_ready = 1'b1;
      for (int k = 0; k < 3; k++) begin
         send(8'h91 + 8'(k));
         chk("R12 stream opcode", 32'(out_opcode), 32'h91 + 32'(k));
      end
      @(negedge clk);
      out_ready = 1'b0;
      chk("R12 stream drained", 32'(out_valid), 32'd0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prefixes();
      t_dup();
      t_fifth();
      t_escape();
      t_hint();
      t_addr();
      t_limit();
      t_handshake();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
      end
   end
endmodule